// File: doc/BRIEF.md
# Dual-Channel 8-Bit Pulse-Width Modulator

The block drives two pulse-width modulated outputs from one system clock. Each channel picks one of four prescaler tap tick inputs as its count rate. It counts 256 ticks per period. Its output is active while the count is below the channel's programmed width. A single 8-bit configuration register holds three things: the combined enable field, each channel's tap select, and each channel's output polarity. Two separate 8-bit width registers set the duty of each channel.

Software writes the width registers at any time. A written width reaches the comparator only at the end of the running period, so the duty changes cleanly between periods. A disabled channel rests at count zero with its output at the inactive level. Enabling it always starts a fresh period that uses the most recently written width.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset both channels are disabled, all configuration bits are zero and both outputs are low.
- R2: Configuration bits [1:0] form the enable field: 00 enables no channel, 01 enables channel 0 only, 10 enables channel 1 only, 11 enables both; a write takes effect on the clock edge that captures it.
- R3: Configuration bits [3:2] select channel 0's tap and bits [5:4] select channel 1's tap; value k (0 to 3) makes the channel count on tap_tick[k].
- R4: Configuration bit 6 is channel 0's polarity and bit 7 is channel 1's polarity; 0 makes the active level high, 1 makes it low.
- R5: An enabled channel's counter advances by one on each tick of its selected tap, so one period lasts 256 ticks.
- R6: Within each period the output is at the active level while the count is less than the channel's width, i.e. for width ticks out of 256.
- R7: A width of 0 keeps the output inactive for the whole period; a width of 255 keeps it active for 255 of 256 ticks.
- R8: A width written while the channel runs takes effect only from the tick that wraps the count from 255 to 0; a width written while the channel is disabled is used from the first period after enabling.
- R9: A disabled channel holds its count at zero and drives the inactive level, and enabling it starts at count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration value: enables, tap selects, polarities |
| wid0_we | input | 1 | Write strobe for channel 0 width |
| wid0_wdata | input | 8 | Channel 0 width value |
| wid1_we | input | 1 | Write strobe for channel 1 width |
| wid1_wdata | input | 8 | Channel 1 width value |
| tap_tick | input | 4 | One-clock tick pulses from four prescaler taps |
| pwm_out | output | 2 | PWM outputs, bit 0 for channel 0, bit 1 for channel 1 |

## Verification
The hardest case to reach from the ports is a width update while a period is running. The new value must stay hidden until the wrap and then govern the whole next period. To reach it, the stimulus enables both channels, rewrites both widths partway through the first period, and measures two back-to-back windows of exactly one period each. The first window must show the old duty and the second the new one. Each window counts the clocks spent at the active level. Its length is 256 tap intervals and it starts on the enabling edge. The count then equals width times the tap interval, wherever the first tick happens to fall.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int unsigned NTAP  = 4;
    localparam int unsigned SEL_W = $clog2(NTAP);
    localparam int unsigned NCH   = 2;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic             pol;
    } chan_cfg_t;

    // Field layout of the 8-bit configuration word
    localparam int unsigned EN_LSB   = 0;
    localparam int unsigned SEL0_LSB = 2;
    localparam int unsigned SEL1_LSB = 4;
    localparam int unsigned POL0_BIT = 6;
    localparam int unsigned POL1_BIT = 7;

    function automatic chan_cfg_t decode_cfg(input logic [7:0] word, input int unsigned ch);
        chan_cfg_t c;
        c.en  = word[EN_LSB + ch];
        c.sel = (ch == 0) ? word[SEL0_LSB +: SEL_W] : word[SEL1_LSB +: SEL_W];
        c.pol = (ch == 0) ? word[POL0_BIT] : word[POL1_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [7:0]                 cfg_wdata,
    input  logic                       wid0_we,
    input  logic [CNT_W-1:0]           wid0_wdata,
    input  logic                       wid1_we,
    input  logic [CNT_W-1:0]           wid1_wdata,
    output chan_cfg_t [NCH-1:0]        cfg,
    output logic [NCH-1:0][CNT_W-1:0]  width
);

    typedef struct packed {
        logic [7:0]                ctrl;
        logic [NCH-1:0][CNT_W-1:0] wid;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we)  r_d.ctrl   = cfg_wdata;
        if (wid0_we) r_d.wid[0] = wid0_wdata;
        if (wid1_we) r_d.wid[1] = wid1_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign cfg[g]   = decode_cfg(r_q.ctrl, g);
        assign width[g] = r_q.wid[g];
    end

    // R2: a configuration write is visible on the next cycle
    p_cfg_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg[0].en == $past(cfg_wdata[0])) && (cfg[1].en == $past(cfg_wdata[1])));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_cfg_t        cfg,
    input  logic [CNT_W-1:0] width,
    input  logic [NTAP-1:0]  tap_tick,
    output logic             pwm
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] shadow;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic     tick;
    logic     wrap;
    logic     active;

    always_comb begin
        tick = tap_tick[cfg.sel];
        wrap = tick && (s_q.cnt == CNT_MAX);
        s_d  = s_q;
        if (!cfg.en) begin
            s_d.cnt    = '0;
            s_d.shadow = width;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (wrap) s_d.shadow = width;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = cfg.en && (s_q.cnt < s_q.shadow);
    assign pwm    = active ^ cfg.pol;

    // R9: disabled channel returns to count zero
    p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (s_q.cnt == '0) || cfg.en);

    // R9: disabled channel sits at its inactive level
    p_inactive_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> pwm == cfg.pol);

    // R5: one step per selected tick, nothing between ticks
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && tick && s_q.cnt != CNT_MAX) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1) || !cfg.en);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !tick) |=> $stable(s_q.cnt) || !cfg.en);

    // R8: width reaches the comparator only at the wrap
    p_wrap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && wrap) |=> (s_q.shadow == $past(width)) && (s_q.cnt == '0 || !cfg.en));
    p_shadow_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !wrap) |=> $stable(s_q.shadow) || !cfg.en);

    // R7: zero width never reaches the active level
    p_zero_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.shadow == '0) |-> pwm == cfg.pol);

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             wid0_we,
    input  logic [CNT_W-1:0] wid0_wdata,
    input  logic             wid1_we,
    input  logic [CNT_W-1:0] wid1_wdata,
    input  logic [NTAP-1:0]  tap_tick,
    output logic [NCH-1:0]   pwm_out
);

    chan_cfg_t [NCH-1:0]       cfg;
    logic [NCH-1:0][CNT_W-1:0] width;

    pwm_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .wid0_we    (wid0_we),
        .wid0_wdata (wid0_wdata),
        .wid1_we    (wid1_we),
        .wid1_wdata (wid1_wdata),
        .cfg        (cfg),
        .width      (width)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg      (cfg[g]),
            .width    (width[g]),
            .tap_tick (tap_tick),
            .pwm      (pwm_out[g])
        );
    end

    // R1: outputs low while reset is held
    always_comb begin
        if (!rst_n) p_reset_low_r1: assert (pwm_out == '0);
    end

endmodule

// File: tb/sim_dual_pwm_gen.sv
module sim_dual_pwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       wid0_we = 1'b0;
    logic [7:0] wid0_wdata = '0;
    logic       wid1_we = 1'b0;
    logic [7:0] wid1_wdata = '0;
    logic [3:0] tap_tick;
    logic [1:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tap divider: tap k ticks once every 2^(k+1) clocks
    logic [3:0] tdiv;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tdiv <= '0;
        else        tdiv <= tdiv + 1'b1;
    end
    assign tap_tick[0] = (tdiv[0]   == 1'b1);
    assign tap_tick[1] = (tdiv[1:0] == 2'b11);
    assign tap_tick[2] = (tdiv[2:0] == 3'b111);
    assign tap_tick[3] = (tdiv[3:0] == 4'b1111);

    dual_pwm_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wid0_we(wid0_we), .wid0_wdata(wid0_wdata),
        .wid1_we(wid1_we), .wid1_wdata(wid1_wdata),
        .tap_tick(tap_tick), .pwm_out(pwm_out)
    );

    typedef struct {
        int    len;
        int    exp0;
        int    exp1;
        logic  act0;
        logic  act1;
        string tag;
    } item_t;

    item_t sb_q[$];
    logic  go = 1'b0;
    logic  busy = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: counts active-level clocks per channel over each window
    initial begin
        forever begin
            wait (go);
            busy = 1'b1;
            @(posedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                int a0;
                int a1;
                it = sb_q.pop_front();
                a0 = 0;
                a1 = 0;
                repeat (it.len) begin
                    @(negedge clk);
                    if (pwm_out[0] === it.act0) a0++;
                    if (pwm_out[1] === it.act1) a1++;
                end
                check({it.tag, " ch0"}, a0, it.exp0);
                check({it.tag, " ch1"}, a1, it.exp1);
            end
            busy = 1'b0;
        end
    end

    task automatic push(input int len, input int e0, input int e1,
                        input logic a0, input logic a1, input string tag);
        item_t it;
        it.len = len; it.exp0 = e0; it.exp1 = e1;
        it.act0 = a0; it.act1 = a1; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_widths(input logic [7:0] w0, input logic [7:0] w1);
        @(negedge clk);
        wid0_we = 1'b1; wid0_wdata = w0;
        wid1_we = 1'b1; wid1_wdata = w1;
        @(negedge clk);
        wid0_we = 1'b0; wid1_we = 1'b0;
    endtask

    // Enable write with the monitor window starting on the capturing edge
    task automatic kick_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v; go = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; go = 1'b0;
    endtask

    task automatic drain;
        wait (!busy && sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic prep(input logic [7:0] w0, input logic [7:0] w1);
        write_cfg(8'h00);
        write_widths(w0, w1);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pwm_out", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after reset pwm_out", int'(pwm_out), 0);

        // R2 R3 R6: enable 01, channel 0 on tap 0 (2 clocks), width 100
        prep(8'd100, 8'd77);
        push(512, 200, 0, 1'b1, 1'b1, "R2 R6 ch0 only tap0 w100");
        kick_cfg(8'h01);
        drain();

        // R2 R3 R4: enable 10, ch1 tap 1 (4 clocks), active low, width 1
        prep(8'd50, 8'd1);
        push(1024, 0, 4, 1'b1, 1'b0, "R2 R3 R4 ch1 only tap1 low w1");
        kick_cfg(8'h92);
        drain();

        // R3 R4 R7: both, ch0 tap2 low width 0, ch1 tap3 width 255
        prep(8'd0, 8'd255);
        push(4096, 0, 4080, 1'b0, 1'b1, "R3 R7 w0 and w255");
        kick_cfg(8'h7B);
        drain();

        // R2 R5 R6: both on tap 0, widths 128 and 255
        prep(8'd128, 8'd255);
        push(512, 256, 510, 1'b1, 1'b1, "R2 R5 both tap0");
        kick_cfg(8'h03);
        drain();

        // R8: widths rewritten mid-period take effect only from next period
        prep(8'd10, 8'd20);
        push(512, 20, 40, 1'b1, 1'b1, "R8 old widths in period 1");
        push(512, 400, 10, 1'b1, 1'b1, "R8 new widths in period 2");
        kick_cfg(8'h03);
        repeat (100) @(negedge clk);
        write_widths(8'd200, 8'd5);
        drain();

        // R9: disable both (polarity low) while running; width writes do nothing
        push(64, 0, 0, 1'b0, 1'b0, "R9 disabled stays inactive");
        kick_cfg(8'hC0);
        write_widths(8'd90, 8'd90);
        drain();
        check("R9 disabled level", int'(pwm_out), 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule